// File: doc/BRIEF.md
# Shared-Channel Degamma Curve with Extended Range

This block linearises pixel components before the colour matrix. It holds one curve of 35 sample points that red, green and blue all use. Points 0 through 32 are spaced evenly over inputs from 0 to 1.0. Two further points sit at inputs of 3.0 and 7.0. Each component is evaluated by linear interpolation between the two points around it, and the result is registered.

Software fills the curve through a two-register write port. A write to the pointer register either sets the write position or switches on auto-advance. A write to the entry register stores one point. When auto-advance is on, the entry write also moves the position forward by one. The bit that switches on auto-advance masks the position field of the same write. Software therefore sets the position to 0 first and then switches on auto-advance. Once the last point has been stored under auto-advance, the port locks until software sets the position again.

Top module: `degam_unit`

## Requirements
- R1: After reset, points 0..32 hold k*2048 (k = point number) and points 33 and 34 hold 0x10000, so inputs up to 1.0 pass through unchanged and larger inputs give 0x10000. The position is 0, auto-advance is off and out_valid is low.
- R2: out_valid equals in_valid delayed by one clock. Each out_* carries the result for the in_* sampled on the same edge that raised out_valid.
- R3: An input x below 0x10000 (unsigned 3.16) uses lo = x[15:11] and f = x[10:0]. The result is P[lo] + floor((P[lo+1]-P[lo])*f/2048), where P[k] is point k, and the difference may be negative.
- R4: For 0x10000 <= x < 0x30000, the same formula is used with lo = 32 and f = (x-0x10000)>>6.
- R5: For 0x30000 <= x < 0x70000, the formula is used with lo = 33 and f = (x-0x30000)>>7. Any x of 0x70000 or above returns P[34].
- R6: All three components read the same curve, and each is evaluated independently of the other two.
- R7: A pointer write (cfg_sel=0) with bit 31 clear sets the position to bits [5:0], saturated at 34. It also turns auto-advance off and removes the lock. Entry writes without auto-advance keep overwriting the same point.
- R8: A pointer write with bit 31 set turns auto-advance on and leaves the position unchanged, whatever its bits [5:0] hold. It does not remove the lock.
- R9: An entry write (cfg_sel=1) stores bits [16:0] at the current position and ignores the upper bits. With auto-advance on, it then advances the position by one.
- R10: After an entry write at position 34 with auto-advance on, further entry writes are ignored until a pointer write with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the pointer register, 1 selects the entry register |
| cfg_wdata | input | 32 | Write data. Pointer register: [5:0] position, [31] auto-advance. Entry register: [16:0] point value |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 19 | Red input, unsigned 3.16 |
| in_g | input | 19 | Green input, unsigned 3.16 |
| in_b | input | 19 | Blue input, unsigned 3.16 |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 17 | Red result, unsigned 1.16 |
| out_g | output | 17 | Green result, unsigned 1.16 |
| out_b | output | 17 | Blue result, unsigned 1.16 |

## Verification
A wrong write position or a missed auto-advance stores a point in the wrong place. This shows as a wrong result one clock after the first pixel that falls in a segment touching that point. A lock that fails to engage or release shows the same way on inputs at or above 3.0. A wrong segment decode in one range shifts every result in that range at once. The bench therefore probes each range just inside both of its edges, including exactly 1.0, 3.0 and 7.0.

// File: rtl/degam_pkg.sv
`timescale 1ns/1ps
package degam_pkg;
   // selects which configuration register a write targets
   typedef enum logic {
      SEL_PTR   = 1'b0,
      SEL_ENTRY = 1'b1
   } cfg_sel_e;

   localparam int N_CH = 3;
endpackage

// File: rtl/degam_regs.sv
`timescale 1ns/1ps
module degam_regs
   import degam_pkg::*;
#(
   parameter int ENTRY_W  = 17,
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5,
   parameter int CFG_W    = 32,
   parameter int AUTO_BIT = 31,
   localparam int N_LIN   = (1 << SEG_BITS) + 1,
   localparam int N_ENT   = N_LIN + 2,
   localparam int IDX_W   = $clog2(N_ENT)
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic                            sel,
   input  logic [CFG_W-1:0]                wdata,
   output logic [N_ENT-1:0][ENTRY_W-1:0]   tbl_o
);
   localparam int F_W = FRAC_W - SEG_BITS;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

   logic [IDX_W-1:0] pos_q;
   logic             auto_q;
   logic             lock_q;
   logic [IDX_W-1:0] pos_field;
   logic             ptr_wr;
   logic             ent_wr;
   logic             ent_we;
   logic             unused_wdata;

   assign ptr_wr    = we && (sel == SEL_PTR);
   assign ent_wr    = we && (sel == SEL_ENTRY);
   assign ent_we    = ent_wr && !lock_q;
   assign pos_field = wdata[IDX_W-1:0];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         auto_q <= 1'b0;
         lock_q <= 1'b0;
      end else if (ptr_wr) begin
         if (wdata[AUTO_BIT]) begin
            auto_q <= 1'b1;
         end else begin
            auto_q <= 1'b0;
            lock_q <= 1'b0;
            pos_q  <= (pos_field > LAST) ? LAST : pos_field;
         end
      end else if (ent_we && auto_q) begin
         if (pos_q == LAST) lock_q <= 1'b1;
         else               pos_q  <= pos_q + IDX_W'(1);
      end
   end

   for (genvar g = 0; g < N_ENT; g++) begin : g_pt
      localparam logic [ENTRY_W-1:0] RST_V =
         (g < N_LIN) ? ENTRY_W'(g << F_W) : ENTRY_W'(1 << FRAC_W);
      logic [ENTRY_W-1:0] pt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pt_q <= RST_V;
         else if (ent_we && pos_q == IDX_W'(g))
            pt_q <= wdata[ENTRY_W-1:0];
      end
      assign tbl_o[g] = pt_q;
   end

   // R7
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST);
   // R8
   auto_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && wdata[AUTO_BIT]) |=> $stable(pos_q));
   // R9
   auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr && auto_q && !lock_q && pos_q != LAST) |=> (pos_q == $past(pos_q) + IDX_W'(1)));
   // R10
   locked_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr && lock_q) |=> $stable(tbl_o));
endmodule

// File: rtl/degam_interp.sv
`timescale 1ns/1ps
module degam_interp #(
   parameter int ENTRY_W  = 17,
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5,
   localparam int N_LIN   = (1 << SEG_BITS) + 1,
   localparam int N_ENT   = N_LIN + 2,
   localparam int IDX_W   = $clog2(N_ENT),
   localparam int IN_W    = FRAC_W + 3
)(
   input  logic [N_ENT-1:0][ENTRY_W-1:0] tbl,
   input  logic [IN_W-1:0]               x,
   output logic [ENTRY_W-1:0]            y
);
   localparam int F_W = FRAC_W - SEG_BITS;
   localparam int PW  = ENTRY_W + F_W + 2;
   localparam logic [IN_W-1:0]  ONE_X   = IN_W'(1) << FRAC_W;
   localparam logic [IN_W-1:0]  THREE_X = IN_W'(3) << FRAC_W;
   localparam logic [IDX_W-1:0] P_ONE   = IDX_W'(N_LIN - 1);
   localparam logic [IDX_W-1:0] P_THREE = IDX_W'(N_LIN);
   localparam logic [IDX_W-1:0] P_SEVEN = IDX_W'(N_LIN + 1);

   logic [2:0]               x_int;
   logic [IN_W-1:0]          d_lo, d_hi;
   logic [IDX_W-1:0]         lo_i, hi_i;
   logic [F_W-1:0]           frac;
   logic [ENTRY_W-1:0]       a, b;
   logic signed [ENTRY_W:0]  diff;
   logic signed [PW-1:0]     prod, sum;
   logic                     unused_bits;

   assign x_int = x[IN_W-1:FRAC_W];
   assign d_lo  = x - ONE_X;
   assign d_hi  = x - THREE_X;

   // range decode: linear span, 1..3, 3..7, saturated
   always_comb begin
      if (x_int == 3'd0) begin
         lo_i = IDX_W'(x[FRAC_W-1:F_W]);
         hi_i = lo_i + IDX_W'(1);
         frac = x[F_W-1:0];
      end else if (x_int < 3'd3) begin
         lo_i = P_ONE;
         hi_i = P_THREE;
         frac = d_lo[FRAC_W:FRAC_W+1-F_W];
      end else if (x_int < 3'd7) begin
         lo_i = P_THREE;
         hi_i = P_SEVEN;
         frac = d_hi[FRAC_W+1:FRAC_W+2-F_W];
      end else begin
         lo_i = P_SEVEN;
         hi_i = P_SEVEN;
         frac = '0;
      end
   end

   assign a    = tbl[lo_i];
   assign b    = tbl[hi_i];
   assign diff = $signed({1'b0, b}) - $signed({1'b0, a});
   assign prod = PW'(diff) * PW'($signed({1'b0, frac}));
   assign sum  = PW'($signed({1'b0, a})) + (prod >>> F_W);
   assign y    = sum[ENTRY_W-1:0];

   assign unused_bits = ^{d_lo, d_hi, sum};
endmodule

// File: rtl/degam_unit.sv
`timescale 1ns/1ps
module degam_unit
   import degam_pkg::*;
#(
   parameter int ENTRY_W  = 17,
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5,
   parameter int CFG_W    = 32,
   parameter int AUTO_BIT = 31,
   localparam int N_LIN   = (1 << SEG_BITS) + 1,
   localparam int N_ENT   = N_LIN + 2,
   localparam int IN_W    = FRAC_W + 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               in_valid,
   input  logic [IN_W-1:0]    in_r,
   input  logic [IN_W-1:0]    in_g,
   input  logic [IN_W-1:0]    in_b,
   output logic               out_valid,
   output logic [ENTRY_W-1:0] out_r,
   output logic [ENTRY_W-1:0] out_g,
   output logic [ENTRY_W-1:0] out_b
);
   if (SEG_BITS >= FRAC_W) begin : g_bad_seg
      $error("SEG_BITS must be below FRAC_W");
   end
   if (ENTRY_W < FRAC_W + 1) begin : g_bad_entry
      $error("ENTRY_W must hold the value 1.0");
   end
   if (AUTO_BIT >= CFG_W || AUTO_BIT < ENTRY_W) begin : g_bad_auto
      $error("AUTO_BIT must lie above the entry field and inside the write word");
   end

   logic [N_ENT-1:0][ENTRY_W-1:0] tbl;
   logic [IN_W-1:0]               ch_x [N_CH];
   logic [ENTRY_W-1:0]            ch_q [N_CH];
   logic                          vld_q;

   degam_regs #(
      .ENTRY_W (ENTRY_W),
      .FRAC_W  (FRAC_W),
      .SEG_BITS(SEG_BITS),
      .CFG_W   (CFG_W),
      .AUTO_BIT(AUTO_BIT)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .sel  (cfg_sel),
      .wdata(cfg_wdata),
      .tbl_o(tbl)
   );

   assign ch_x[0] = in_r;
   assign ch_x[1] = in_g;
   assign ch_x[2] = in_b;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [ENTRY_W-1:0] y_c;
      logic [ENTRY_W-1:0] y_q;
      degam_interp #(
         .ENTRY_W (ENTRY_W),
         .FRAC_W  (FRAC_W),
         .SEG_BITS(SEG_BITS)
      ) u_interp (
         .tbl(tbl),
         .x  (ch_x[c]),
         .y  (y_c)
      );
      always_ff @(posedge clk) begin
         if (!rst_n)        y_q <= '0;
         else if (in_valid) y_q <= y_c;
      end
      assign ch_q[c] = y_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= in_valid;
   end

   assign out_valid = vld_q;
   assign out_r     = ch_q[0];
   assign out_g     = ch_q[1];
   assign out_b     = ch_q[2];

   // R2
   vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R5
   sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (&in_r[IN_W-1:FRAC_W])) |=> (out_r == $past(tbl[N_ENT-1])));
endmodule

// File: tb/test_degam_unit.sv
`timescale 1ns/1ps
module test_degam_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [18:0] in_r = '0, in_g = '0, in_b = '0;
   logic        out_valid;
   logic [16:0] out_r, out_g, out_b;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;
   int mdl [35];

   localparam int NV = 10;
   localparam int VX [NV] = '{0, 32'h00800, 32'h01234, 32'h0FFFF, 32'h10000,
                              32'h1FFFF, 32'h30000, 32'h5ABCD, 32'h70000, 32'h7FFFF};
   localparam int VY [NV] = '{0, 32'h00800, 32'h01234, 32'h0FFFF, 32'h10000,
                              32'h10000, 32'h10000, 32'h10000, 32'h10000, 32'h10000};

   always #2.5 clk = ~clk;

   degam_unit i_degam_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_r(in_r), .in_g(in_g),
      .in_b(in_b), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int ref_y(int x);
      int lo, f, p;
      if (x >= 7 * 65536) return mdl[34];
      if (x < 65536) begin
         lo = x / 2048; f = x % 2048;
      end else if (x < 3 * 65536) begin
         lo = 32; f = (x - 65536) / 64;
      end else begin
         lo = 33; f = (x - 3 * 65536) / 128;
      end
      p = (mdl[lo + 1] - mdl[lo]) * f;
      return mdl[lo] + (p >>> 11);
   endfunction

   task automatic wr(bit sel, int unsigned data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pix(string req, int xr, int xg, int xb);
      @(negedge clk);
      in_valid = 1'b1; in_r = 19'(xr); in_g = 19'(xg); in_b = 19'(xb);
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " valid"}, int'(out_valid), 1);
      chk({req, " red"},   int'(out_r), ref_y(xr));
      chk({req, " green"}, int'(out_g), ref_y(xg));
      chk({req, " blue"},  int'(out_b), ref_y(xb));
   endtask

   task automatic load_curve(string req);
      wr(1'b0, 0);
      wr(1'b0, 32'h8000_0000);
      for (int i = 0; i < 35; i++) wr(1'b1, 32'hFFFE_0000 | 32'(mdl[i]));
      pix(req, 32'h00800, 32'h01234, 32'h0F000);
      pix(req, 32'h10000, 32'h18000, 32'h2FFFF);
      pix(req, 32'h30000, 32'h4567F, 32'h6FFFF);
      pix(req, 32'h70000, 32'h7FFFF, 32'h0FFFF);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         summary();
      end
   end

   initial begin
      for (int i = 0; i < 35; i++) mdl[i] = (i < 33) ? i * 2048 : 65536;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 R2 out_valid after reset", int'(out_valid), 0);

      // R1 R3 R4 R5: reset curve, walked from the vector table
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         in_valid = 1'b1; in_r = 19'(VX[v]); in_g = 19'(VX[v]); in_b = 19'(VX[v]);
         @(negedge clk);
         in_valid = 1'b0;
         chk("R1 reset curve red", int'(out_r), VY[v]);
         chk("R1 reset curve blue", int'(out_b), VY[v]);
      end

      // R2: no input, no output valid
      @(negedge clk);
      chk("R2 idle out_valid", int'(out_valid), 0);

      // R9 R6 R3 R4 R5: linear software curve, upper data bits set
      for (int i = 0; i < 35; i++) mdl[i] = i * 65536 / 34;
      load_curve("R9 R6 linear");

      // R3 R4 R5 R6: falling curve with odd extended points
      for (int i = 0; i < 33; i++) mdl[i] = 60000 - i * 1700;
      mdl[33] = 100000; mdl[34] = 3000;
      load_curve("R3 R4 R5 falling");

      // R8: auto bit masks the position field
      wr(1'b0, 5);
      wr(1'b0, 32'h8000_0014);
      wr(1'b1, 32'h1111);
      wr(1'b1, 32'h2222);
      mdl[5] = 32'h1111; mdl[6] = 32'h2222;
      pix("R8 auto ignores position", 5 * 2048, 6 * 2048, 20 * 2048);

      // R7: no auto, same point overwritten
      wr(1'b0, 10);
      wr(1'b1, 32'h3333);
      wr(1'b1, 32'h4444);
      mdl[10] = 32'h4444;
      pix("R7 overwrite in place", 10 * 2048, 11 * 2048, 10 * 2048 + 1024);

      // R10: lock after last point
      wr(1'b0, 33);
      wr(1'b0, 32'h8000_0000);
      wr(1'b1, 32'h5555);
      wr(1'b1, 32'h6666);
      wr(1'b1, 32'h7777);
      mdl[33] = 32'h5555; mdl[34] = 32'h6666;
      pix("R10 lock", 32'h30000, 32'h70000, 32'h50000);
      wr(1'b0, 32'h8000_0000);
      wr(1'b1, 32'h1234);
      pix("R10 auto write keeps lock", 32'h70000, 32'h30000, 32'h7FFFF);
      wr(1'b0, 34);
      wr(1'b1, 32'h0ABC);
      mdl[34] = 32'h0ABC;
      pix("R10 R7 unlock", 32'h70000, 32'h60000, 32'h30000);

      // R7: out-of-range position saturates at 34
      wr(1'b0, 63);
      wr(1'b1, 32'h0DEF);
      mdl[34] = 32'h0DEF;
      pix("R7 position saturation", 32'h7FFFF, 32'h40000, 32'h0FFFF);

      finished = 1;
      summary();
   end
endmodule